// File: doc/BRIEF.md
# Operate-Group Execution Unit

This unit executes the register-operate instructions of a 12-bit accumulator machine with a one-bit link. It takes the instruction word together with the current accumulator and link. From these it produces the next accumulator, the next link, a request to advance the program counter by one, and a flag that marks an extended-arithmetic instruction. Instruction bits are numbered from 0 at the most significant end, so bit k of the instruction sits on `instr_i[11-k]`. The opcode is bits 0 to 2.

A group-1 instruction is a small program of sub-operations on the link and the accumulator. The clears run first and the complements run after them. A group-2 instruction tests the accumulator against one of eight conditions, chosen by three scattered instruction bits. The unit registers its results, so the results of an instruction appear one clock after it is presented. The extended-arithmetic operations themselves happen elsewhere. This unit only flags them.

Top module: `opr_exec_unit`

## Requirements
- R1: While rst_ni is low, and after its release until the first clock edge, ac_o, link_o, skip_o and ext_o are all 0.
- R2: When the opcode (instr_i[11:9]) is not 7, one clock later ac_o and link_o equal the presented ac_i and link_i, and skip_o and ext_o are 0.
- R3: With opcode 7, instruction bit 3 (instr_i[8]) = 0 selects group 1. Bits {3,11} (instr_i[8], instr_i[0]) = 10 select group 2, and 11 selects the extended group.
- R4: In group 1 the link is cleared by bit 5 (instr_i[6]) and then complemented by bit 7 (instr_i[4]). {5,7} = 00 holds, 10 gives 0, 01 gives the inverse, and 11 gives 1.
- R5: In group 1 the accumulator is cleared by bit 4 (instr_i[7]) in the same sub-step as the link clear, and complemented by bit 6 (instr_i[5]) in the same sub-step as the link complement. Both together give all ones.
- R6: In group 2 the skip code is {bit 5, bit 6, bit 8} = {instr_i[6], instr_i[5], instr_i[3]}, with bit 5 as the MSB.
- R7: The skip codes 0 to 7 request a skip for never, always, AC==0, AC!=0, AC<0, AC>=0, AC<=0 and AC>0, with AC taken as signed two's complement. skip_o is 1 one clock later when the condition holds.
- R8: A group-2 instruction leaves the accumulator and the link unchanged, and ext_o is 0.
- R9: An extended-group instruction sets ext_o one clock later, leaves the accumulator and the link unchanged, and gives skip_o = 0.
- R10: skip_o is 1 only for group 2, and ext_o is 1 only for the extended group. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 12 | Instruction word, bit 0 at index 11 |
| ac_i | input | DATA_W | Current accumulator |
| link_i | input | 1 | Current link |
| ac_o | output | DATA_W | Next accumulator, registered |
| link_o | output | 1 | Next link, registered |
| skip_o | output | 1 | Program counter increment request |
| ext_o | output | 1 | Extended-arithmetic instruction flag |

## Verification
The bench builds the unit with the default DATA_W of 12. With this width the sign bit and the zero test sit exactly where the skip codes expect them. Directed accumulator values of 0, 1, 0x7FF, 0x800 and 0xFFF hit each edge of the signed compare for every skip code. Random instructions forced to opcode 7 cover all four link sub-step combinations, both accumulator operations and the group boundaries. Random instructions with other opcodes exercise the pass-through path.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int unsigned INSTR_W = 12;
  localparam int unsigned OPC_W   = 3;
  localparam logic [OPC_W-1:0] OPC_OPR = 3'd7;

  // bit k (0 = MSB) lives at index INSTR_W-1-k
  localparam int unsigned IX_GRP   = INSTR_W - 1 - 3;
  localparam int unsigned IX_CLA   = INSTR_W - 1 - 4;
  localparam int unsigned IX_CLL   = INSTR_W - 1 - 5;
  localparam int unsigned IX_CMA   = INSTR_W - 1 - 6;
  localparam int unsigned IX_CML   = INSTR_W - 1 - 7;
  localparam int unsigned IX_SK_LO = INSTR_W - 1 - 8;
  localparam int unsigned IX_SUB   = INSTR_W - 1 - 11;

  localparam int unsigned SUB_STEPS = 2;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_ONE  = 2'd1,
    GRP_TWO  = 2'd2,
    GRP_EXT  = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SK_NEVER = 3'd0,
    SK_ALWAYS = 3'd1,
    SK_ZERO = 3'd2,
    SK_NZERO = 3'd3,
    SK_NEG = 3'd4,
    SK_NNEG = 3'd5,
    SK_LEZ = 3'd6,
    SK_GTZ = 3'd7
  } skip_e;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output grp_e               grp_o,
  output skip_e              skip_code_o
);
  logic is_opr;
  assign is_opr = (instr_i[INSTR_W-1 -: OPC_W] == OPC_OPR);

  always_comb begin
    grp_o = GRP_NONE;
    if (is_opr) begin
      unique case ({instr_i[IX_GRP], instr_i[IX_SUB]})
        2'b10:   grp_o = GRP_TWO;
        2'b11:   grp_o = GRP_EXT;
        default: grp_o = GRP_ONE;
      endcase
    end
  end

  assign skip_code_o = skip_e'({instr_i[IX_CLL], instr_i[IX_CMA], instr_i[IX_SK_LO]});
endmodule

// File: rtl/opr_group1.sv
module opr_group1
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  ac_i,
  input  logic               link_i,
  output logic [DATA_W-1:0]  ac_o,
  output logic               link_o
);
  // state after each sub-step; index 0 is the input
  logic [DATA_W-1:0] ac_s   [SUB_STEPS+1];
  logic              link_s [SUB_STEPS+1];

  assign ac_s[0]   = ac_i;
  assign link_s[0] = link_i;

  for (genvar s = 0; s < SUB_STEPS; s++) begin : g_step
    if (s == 0) begin : g_clear
      assign ac_s[s+1]   = instr_i[IX_CLA] ? '0   : ac_s[s];
      assign link_s[s+1] = instr_i[IX_CLL] ? 1'b0 : link_s[s];
    end else begin : g_compl
      assign ac_s[s+1]   = instr_i[IX_CMA] ? ~ac_s[s]   : ac_s[s];
      assign link_s[s+1] = instr_i[IX_CML] ? ~link_s[s] : link_s[s];
    end
  end

  assign ac_o   = ac_s[SUB_STEPS];
  assign link_o = link_s[SUB_STEPS];
endmodule

// File: rtl/opr_skip_eval.sv
module opr_skip_eval
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] ac_i,
  input  skip_e             code_i,
  output logic              hit_o
);
  logic neg, zero;
  assign neg  = ac_i[DATA_W-1];
  assign zero = (ac_i == '0);

  always_comb begin
    unique case (code_i)
      SK_NEVER:  hit_o = 1'b0;
      SK_ALWAYS: hit_o = 1'b1;
      SK_ZERO:   hit_o = zero;
      SK_NZERO:  hit_o = !zero;
      SK_NEG:    hit_o = neg;
      SK_NNEG:   hit_o = !neg;
      SK_LEZ:    hit_o = neg || zero;
      SK_GTZ:    hit_o = !neg && !zero;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/opr_exec_unit.sv
module opr_exec_unit
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       instr_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              link_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              link_o,
  output logic              skip_o,
  output logic              ext_o
);
  grp_e              grp;
  skip_e             skip_code;
  logic [DATA_W-1:0] g1_ac;
  logic              g1_link;
  logic              sk_hit;

  logic [DATA_W-1:0] ac_d;
  logic              link_d, skip_d, ext_d;

  opr_decode u_decode (
    .instr_i     (instr_i),
    .grp_o       (grp),
    .skip_code_o (skip_code)
  );

  opr_group1 #(.DATA_W(DATA_W)) u_group1 (
    .instr_i (instr_i),
    .ac_i    (ac_i),
    .link_i  (link_i),
    .ac_o    (g1_ac),
    .link_o  (g1_link)
  );

  opr_skip_eval #(.DATA_W(DATA_W)) u_skip (
    .ac_i   (ac_i),
    .code_i (skip_code),
    .hit_o  (sk_hit)
  );

  always_comb begin
    ac_d   = ac_i;
    link_d = link_i;
    skip_d = 1'b0;
    ext_d  = 1'b0;
    unique case (grp)
      GRP_ONE: begin
        ac_d   = g1_ac;
        link_d = g1_link;
      end
      GRP_TWO: skip_d = sk_hit;
      GRP_EXT: ext_d  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_o   <= '0;
      link_o <= 1'b0;
      skip_o <= 1'b0;
      ext_o  <= 1'b0;
    end else begin
      ac_o   <= ac_d;
      link_o <= link_d;
      skip_o <= skip_d;
      ext_o  <= ext_d;
    end
  end
endmodule

// File: rtl/opr_exec_unit_chk.sv
module opr_exec_unit_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [11:0]       instr_i,
  input logic [DATA_W-1:0] ac_i,
  input logic              link_i,
  input logic [DATA_W-1:0] ac_o,
  input logic              link_o,
  input logic              skip_o,
  input logic              ext_o
);
  logic opr, g1, g2, gx;
  assign opr = (instr_i[11:9] == 3'd7);
  assign g1  = opr && !instr_i[8];
  assign g2  = opr && instr_i[8] && !instr_i[0];
  assign gx  = opr && instr_i[8] && instr_i[0];

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (ac_o == '0 && !link_o && !skip_o && !ext_o); // R1
  end

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opr |=> (ac_o == $past(ac_i) && link_o == $past(link_i) && !skip_o && !ext_o)); // R2
  AST_SET_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g1 && instr_i[6] && instr_i[4]) |=> link_o); // R4
  AST_CLR_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g1 && instr_i[6] && !instr_i[4]) |=> !link_o); // R4
  AST_AC_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g1 && instr_i[7] && instr_i[5]) |=> (ac_o == '1)); // R5
  AST_SKIP_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g2 && {instr_i[6], instr_i[5], instr_i[3]} == 3'd0) |=> !skip_o); // R7
  AST_SKIP_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g2 && {instr_i[6], instr_i[5], instr_i[3]} == 3'd1) |=> skip_o); // R6
  AST_G2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g2 |=> (ac_o == $past(ac_i) && link_o == $past(link_i) && !ext_o)); // R8
  AST_EXT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gx |=> (ext_o && !skip_o && ac_o == $past(ac_i) && link_o == $past(link_i))); // R9
  AST_G1_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g1 |=> (!skip_o && !ext_o)); // R3
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({skip_o, ext_o})); // R10
endmodule

bind opr_exec_unit opr_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .instr_i (instr_i),
  .ac_i    (ac_i),
  .link_i  (link_i),
  .ac_o    (ac_o),
  .link_o  (link_o),
  .skip_o  (skip_o),
  .ext_o   (ext_o)
);

// File: tb/opr_exec_unit_bench.sv
module opr_exec_unit_bench;
  localparam int unsigned DATA_W = 12;
  localparam time CLK_PERIOD = 10ns;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [11:0]       instr_i = '0;
  logic [DATA_W-1:0] ac_i = '0;
  logic              link_i = 1'b0;
  logic [DATA_W-1:0] ac_o;
  logic              link_o, skip_o, ext_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  opr_exec_unit #(.DATA_W(DATA_W)) u_opr_exec_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .ac_i(ac_i), .link_i(link_i),
    .ac_o(ac_o), .link_o(link_o), .skip_o(skip_o), .ext_o(ext_o)
  );

  typedef struct packed {
    logic [DATA_W-1:0] ac;
    logic              link;
    logic              skip;
    logic              ext;
  } res_t;

  function automatic string req_of(logic [11:0] ins);
    if (ins[11:9] != 3'd7) return "R2";
    if (!ins[8]) return "R4/R5";
    if (!ins[0]) return "R7";
    return "R9";
  endfunction

  function automatic res_t model(logic [11:0] ins, logic [DATA_W-1:0] a, logic l);
    res_t r;
    logic [2:0] c;
    logic neg, zero;
    r = '{ac: a, link: l, skip: 1'b0, ext: 1'b0};
    if (ins[11:9] != 3'd7) return r;
    if (!ins[8]) begin
      if (ins[7]) r.ac = '0;
      if (ins[6]) r.link = 1'b0;
      if (ins[5]) r.ac = ~r.ac;
      if (ins[4]) r.link = ~r.link;
    end else if (!ins[0]) begin
      c = {ins[6], ins[5], ins[3]};
      neg = a[DATA_W-1];
      zero = (a == '0);
      case (c)
        3'd0: r.skip = 1'b0;
        3'd1: r.skip = 1'b1;
        3'd2: r.skip = zero;
        3'd3: r.skip = !zero;
        3'd4: r.skip = neg;
        3'd5: r.skip = !neg;
        3'd6: r.skip = neg || zero;
        default: r.skip = !neg && !zero;
      endcase
    end else begin
      r.ext = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string req, res_t exp);
    res_t act;
    act = '{ac: ac_o, link: link_o, skip: skip_o, ext: ext_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: instr=%o actual ac=%h l=%b sk=%b ex=%b expected ac=%h l=%b sk=%b ex=%b",
               req, instr_i, act.ac, act.link, act.skip, act.ext,
               exp.ac, exp.link, exp.skip, exp.ext);
    end
  endtask

  // drive at negedge, sample after the next rising edge
  task automatic run(logic [11:0] ins, logic [DATA_W-1:0] a, logic l, string req);
    @(negedge clk_i);
    instr_i = ins; ac_i = a; link_i = l;
    @(posedge clk_i);
    #1;
    check(req, model(ins, a, l));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] corner [5];
    int unsigned seed;
    seed = 32'h5eed_0b17;
    void'($urandom(seed));
    corner = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFF};

    instr_i = 12'o7777; ac_i = 12'hABC; link_i = 1'b1;
    #(CLK_PERIOD * 3);
    check("R1", '{ac: '0, link: 1'b0, skip: 1'b0, ext: 1'b0});
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1", '{ac: '0, link: 1'b0, skip: 1'b0, ext: 1'b0});

    // R4 link sub-step order, R5 accumulator ops
    for (int b = 0; b < 16; b++) begin
      run({3'd7, 1'b0, b[3], b[2], b[1], b[0], 4'b0000}, 12'h5A3, 1'b0, "R4/R5");
      run({3'd7, 1'b0, b[3], b[2], b[1], b[0], 4'b0000}, 12'h5A3, 1'b1, "R4/R5");
    end
    // R3 group boundary: bit 11 is don't-care in group 1
    run(12'o7241, 12'h123, 1'b1, "R3");
    run(12'o7601, 12'h123, 1'b0, "R3");
    // R6/R7 every skip code against signed corners
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 5; k++) begin
        run({3'd7, 1'b1, 1'b0, c[2], c[1], 1'b0, c[0], 2'b00, 1'b0}, corner[k], k[0], "R7");
      end
    end
    // R9 extended group
    run(12'o7401, 12'h777, 1'b1, "R9");
    run(12'o7777, 12'h000, 1'b0, "R9");
    // R2 other opcodes
    for (int o = 0; o < 7; o++) run({o[2:0], 9'o525}, 12'h3C3, 1'b1, "R2");

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] ins;
      ins = 12'($urandom());
      if (i % 2 == 0) ins[11:9] = 3'd7;
      run(ins, DATA_W'($urandom()), 1'($urandom()), req_of(ins));
    end

    // R10 flags exclusive after the last random step
    checks++;
    if (skip_o && ext_o) begin
      errors++;
      $display("FAIL R10: actual skip=%b ext=%b expected not both", skip_o, ext_o);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule